// File: doc/BRIEF.md
# Move-Oriented Multi-Cycle Register Processor

This block is a small processor core built around a single shared memory port. It fetches one 16-bit instruction word at a time, decodes an 8-bit opcode and two 4-bit operand fields, and runs each instruction class for a fixed number of cycles. The instruction set is centred on moves: register to register, register from an immediate, loads and stores through a register-held address, an immediate store, push and pop through a stack pointer, and four bitwise ALU operations. Any instruction whose destination is the instruction pointer acts as an unconditional jump.

There are eight general registers plus a separate stack pointer and instruction pointer. Memory is word addressed. The memory port has no handshake and no back-pressure. The core expects read data to follow the address in the same cycle, and it expects a write to become visible from the next cycle. The core fetches during the execute cycle of every instruction. Ordinary moves therefore complete in one cycle. ALU operations, loads, stores, push, pop and immediate loads take a second cycle, and the immediate store takes a third.

Top module: `mvcore`

## Requirements
- R1: Reset is synchronous and active high. It sets IP to 0, SP to 0xFFFE and r0–r7 to zero. The first cycle after reset fetches from address 0.
- R2: Every instruction begins with a fetch cycle that reads the word at IP with mem_we low. In the word, bits [15:8] are the opcode, bits [7:4] are operand A and bits [3:0] are operand B. Operand codes 0–7 select r0–r7, code 8 selects SP and code 9 selects IP.
- R3: Opcode 0x01 copies B into A in one cycle. The next fetch follows in the very next cycle, at IP+1.
- R4: Opcode 0x02 spends a second cycle reading the immediate word at the opcode address + 1 and writes that word into A. The next fetch is at the opcode address + 2.
- R5: When an instruction writes operand code 9, the next fetch comes from the written value.
- R6: Opcodes 0x10 (AND), 0x11 (OR) and 0x12 (XOR) set A to A op B. Opcode 0x13 sets A to ~B. Each takes two cycles, and mem_we stays low in the second cycle.
- R7: Opcode 0x03 takes two cycles. The second cycle reads memory at the address held in B and writes the word into A.
- R8: Opcode 0x04 takes two cycles. The second cycle writes B's value to the address held in A, with mem_we high.
- R9: Opcode 0x05 takes three cycles: the fetch, an immediate read at the opcode address + 1, and a write of that immediate to the address held in A.
- R10: Opcode 0x06 takes two cycles. It decrements SP and writes B's value (read before the decrement) at the new SP. Opcode 0x07 takes two cycles. It reads at SP, writes the word into A and increments SP; if A is SP, the loaded word wins. A push followed by a pop restores SP.
- R11: A fetch in the cycle right after a memory write returns the newly written word, including when the write targets the next instruction.
- R12: Operand codes 9–15 read as zero. Writes to codes 10–15 are discarded. Every other opcode is a one-cycle no-op that advances IP by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Word address for fetch, read or write |
| mem_wdata | output | 16 | Data to write, valid when mem_we is high |
| mem_rdata | input | 16 | Word at mem_addr, same cycle |
| mem_we | output | 1 | Write strobe, one cycle per write |

## Verification
The assertions assume that the memory answers combinationally in the cycle the address is driven, and that a word written at a clock edge is returned from that edge onward. They also assume reset is held across at least one rising edge. The bench memory is an array read by a continuous assignment and written on the rising edge. Reset is held for several cycles before each run. A reference model in the bench aliases addresses into 256 words in exactly the same way as that memory, so random programs may jump, push and overwrite their own code without leaving the assumed behaviour.

// File: rtl/mvcore_pkg.sv
package mvcore_pkg;

  localparam int OP_W   = 8;
  localparam int CODE_W = 4;

  localparam logic [OP_W-1:0] OP_MOV   = 8'h01;
  localparam logic [OP_W-1:0] OP_MOVI  = 8'h02;
  localparam logic [OP_W-1:0] OP_LOAD  = 8'h03;
  localparam logic [OP_W-1:0] OP_STORE = 8'h04;
  localparam logic [OP_W-1:0] OP_STI   = 8'h05;
  localparam logic [OP_W-1:0] OP_PUSH  = 8'h06;
  localparam logic [OP_W-1:0] OP_POP   = 8'h07;
  localparam logic [OP_W-1:0] OP_AND   = 8'h10;

  typedef enum logic [1:0] {
    ST_EXEC,
    ST_IMM,
    ST_MEM,
    ST_ALU
  } state_e;

endpackage

// File: rtl/mvcore_regfile.sv
module mvcore_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IDXW-1:0] widx,
  input  logic [DW-1:0]   wdata,
  input  logic [IDXW-1:0] ra_idx,
  input  logic [IDXW-1:0] rb_idx,
  output logic [DW-1:0]   ra_data,
  output logic [DW-1:0]   rb_data
);

  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[g] <= '0;
      end else if (we && (widx == IDXW'(g))) begin
        regs_q[g] <= wdata;
      end
    end
  end

  assign ra_data = regs_q[ra_idx];
  assign rb_data = regs_q[rb_idx];

endmodule

// File: rtl/mvcore_alu.sv
module mvcore_alu #(
  parameter int DW = 16
) (
  input  logic [1:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  always_comb begin
    unique case (op)
      2'd0:    y = a & b;
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = ~b;
    endcase
  end

endmodule

// File: rtl/mvcore_ctrl.sv
module mvcore_ctrl
  import mvcore_pkg::*;
#(
  parameter int            DW       = 16,
  parameter int            NREG     = 8,
  parameter logic [DW-1:0] SP_RESET = 16'hFFFE,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            mem_we,
  output logic [IDXW-1:0] rf_a_idx,
  output logic [IDXW-1:0] rf_b_idx,
  input  logic [DW-1:0]   rf_a_data,
  input  logic [DW-1:0]   rf_b_data,
  output logic            rf_we,
  output logic [IDXW-1:0] rf_widx,
  output logic [DW-1:0]   rf_wdata,
  output logic [1:0]      alu_op,
  output logic [DW-1:0]   alu_a,
  output logic [DW-1:0]   alu_b,
  input  logic [DW-1:0]   alu_y
);

  localparam logic [CODE_W-1:0] SP_CODE = CODE_W'(NREG);
  localparam logic [CODE_W-1:0] IP_CODE = CODE_W'(NREG + 1);

  state_e              state_q, state_d;
  logic [DW-1:0]       ir_q, ir_d, imm_q, imm_d;
  logic [DW-1:0]       ip_q, ip_d, sp_q, sp_d;
  logic [DW-1:0]       instr;
  logic [OP_W-1:0]     opc;
  logic [CODE_W-1:0]   a_code, b_code;
  logic [DW-1:0]       a_val, b_val;
  logic                is_alu;
  logic                wr_en;
  logic [CODE_W-1:0]   wr_code;
  logic [DW-1:0]       wr_val;

  // Decode from the live memory word while fetching, from the held word after.
  always_comb begin
    instr  = (state_q == ST_EXEC) ? mem_rdata : ir_q;
    opc    = instr[15:8];
    a_code = instr[7:4];
    b_code = instr[3:0];
    is_alu = (opc[7:2] == OP_AND[7:2]);
  end

  assign rf_a_idx = a_code[IDXW-1:0];
  assign rf_b_idx = b_code[IDXW-1:0];
  assign a_val = (a_code < SP_CODE) ? rf_a_data : (a_code == SP_CODE) ? sp_q : '0;
  assign b_val = (b_code < SP_CODE) ? rf_b_data : (b_code == SP_CODE) ? sp_q : '0;
  assign alu_op = opc[1:0];
  assign alu_a  = a_val;
  assign alu_b  = b_val;

  always_comb begin
    state_d   = ST_EXEC;
    ir_d      = ir_q;
    imm_d     = imm_q;
    ip_d      = ip_q;
    sp_d      = sp_q;
    mem_addr  = ip_q;
    mem_we    = 1'b0;
    mem_wdata = '0;
    wr_en     = 1'b0;
    wr_code   = a_code;
    wr_val    = '0;
    unique case (state_q)
      ST_EXEC: begin
        ir_d = mem_rdata;
        ip_d = ip_q + DW'(1);
        if (opc == OP_MOV) begin
          wr_en  = 1'b1;
          wr_val = b_val;
        end else if (opc == OP_MOVI || opc == OP_STI) begin
          state_d = ST_IMM;
        end else if (opc == OP_LOAD || opc == OP_STORE ||
                     opc == OP_PUSH || opc == OP_POP) begin
          state_d = ST_MEM;
        end else if (is_alu) begin
          state_d = ST_ALU;
        end
      end
      ST_IMM: begin
        ip_d  = ip_q + DW'(1);
        imm_d = mem_rdata;
        if (opc == OP_MOVI) begin
          wr_en  = 1'b1;
          wr_val = mem_rdata;
        end else begin
          state_d = ST_MEM;
        end
      end
      ST_MEM: begin
        unique case (opc)
          OP_LOAD: begin
            mem_addr = b_val;
            wr_en    = 1'b1;
            wr_val   = mem_rdata;
          end
          OP_STORE: begin
            mem_addr  = a_val;
            mem_we    = 1'b1;
            mem_wdata = b_val;
          end
          OP_STI: begin
            mem_addr  = a_val;
            mem_we    = 1'b1;
            mem_wdata = imm_q;
          end
          OP_PUSH: begin
            mem_addr  = sp_q - DW'(1);
            mem_we    = 1'b1;
            mem_wdata = b_val;
            sp_d      = sp_q - DW'(1);
          end
          default: begin
            mem_addr = sp_q;
            sp_d     = sp_q + DW'(1);
            wr_en    = 1'b1;
            wr_val   = mem_rdata;
          end
        endcase
      end
      default: begin
        wr_en  = 1'b1;
        wr_val = alu_y;
      end
    endcase
    // Writes to SP or IP override the implicit step.
    if (wr_en && wr_code == SP_CODE) sp_d = wr_val;
    if (wr_en && wr_code == IP_CODE) ip_d = wr_val;
  end

  assign rf_we    = wr_en && (wr_code < SP_CODE);
  assign rf_widx  = wr_code[IDXW-1:0];
  assign rf_wdata = wr_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_EXEC;
      ir_q    <= '0;
      imm_q   <= '0;
      ip_q    <= '0;
      sp_q    <= SP_RESET;
    end else begin
      state_q <= state_d;
      ir_q    <= ir_d;
      imm_q   <= imm_d;
      ip_q    <= ip_d;
      sp_q    <= sp_d;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ip_q == '0 && sp_q == SP_RESET && state_q == ST_EXEC));

  a_r2_fetch_no_write: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXEC) |-> !mem_we);

  a_r11_write_only_in_mem: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (state_q == ST_MEM));

  a_r3_mov_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXEC && opc == OP_MOV) |=> (state_q == ST_EXEC));

  a_r6_alu_enter: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXEC && is_alu) |=> (state_q == ST_ALU));

  a_r6_alu_leave: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ALU) |=> (state_q == ST_EXEC));

  a_r9_sti_sequence: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXEC && opc == OP_STI) |=> (state_q == ST_IMM) ##1 (state_q == ST_MEM));

  a_r10_push_dec: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MEM && opc == OP_PUSH) |=> (sp_q == $past(sp_q) - DW'(1)));

  a_r10_pop_inc: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MEM && opc == OP_POP && a_code != SP_CODE)
      |=> (sp_q == $past(sp_q) + DW'(1)));

  a_r5_ip_redirect: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_code == IP_CODE) |=> (mem_addr == $past(wr_val)));

endmodule

// File: rtl/mvcore.sv
module mvcore #(
  parameter int            DW       = 16,
  parameter int            NREG     = 8,
  parameter logic [DW-1:0] SP_RESET = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we
);

  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [IDXW-1:0] rf_a_idx, rf_b_idx, rf_widx;
  logic [DW-1:0]   rf_a_data, rf_b_data, rf_wdata;
  logic            rf_we;
  logic [1:0]      alu_op;
  logic [DW-1:0]   alu_a, alu_b, alu_y;

  mvcore_ctrl #(.DW(DW), .NREG(NREG), .SP_RESET(SP_RESET)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .rf_a_idx  (rf_a_idx),
    .rf_b_idx  (rf_b_idx),
    .rf_a_data (rf_a_data),
    .rf_b_data (rf_b_data),
    .rf_we     (rf_we),
    .rf_widx   (rf_widx),
    .rf_wdata  (rf_wdata),
    .alu_op    (alu_op),
    .alu_a     (alu_a),
    .alu_b     (alu_b),
    .alu_y     (alu_y)
  );

  mvcore_regfile #(.DW(DW), .NREG(NREG)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .widx    (rf_widx),
    .wdata   (rf_wdata),
    .ra_idx  (rf_a_idx),
    .rb_idx  (rf_b_idx),
    .ra_data (rf_a_data),
    .rb_data (rf_b_data)
  );

  mvcore_alu #(.DW(DW)) alu_i (
    .op (alu_op),
    .a  (alu_a),
    .b  (alu_b),
    .y  (alu_y)
  );

endmodule

// File: tb/mvcore_tb_top.sv
`timescale 1ns/1ps
module mvcore_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;
  logic [15:0] mem [256];

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mvcore #(.DW(16), .NREG(8), .SP_RESET(16'hFFFE)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  // Reference model state
  logic [15:0] mm [256];
  logic [15:0] mr [8];
  logic [15:0] msp, mip;
  string       pend;

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rv(input logic [3:0] c);
    if (c < 4'd8) return mr[c[2:0]];
    if (c == 4'd8) return msp;
    return 16'h0000;
  endfunction

  task automatic wr(input logic [3:0] c, input logic [15:0] v);
    if (c < 4'd8) mr[c[2:0]] = v;
    else if (c == 4'd8) msp = v;
    else if (c == 4'd9) mip = v;
  endtask

  function automatic logic [15:0] alu_ref(input logic [1:0] op, input logic [15:0] a,
                                          input logic [15:0] b);
    case (op)
      2'd0:    return a & b;
      2'd1:    return a | b;
      2'd2:    return a ^ b;
      default: return ~b;
    endcase
  endfunction

  task automatic poke(input int a, input logic [15:0] w);
    mem[a] = w;
    mm[a]  = w;
  endtask

  task automatic bus(input string req, input logic [15:0] a, input logic we,
                     input logic [15:0] wd);
    chk(req, "addr", mem_addr, a);
    chk(req, "we", {15'b0, mem_we}, {15'b0, we});
    if (we) chk(req, "wdata", mem_wdata, wd);
    @(negedge clk);
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic release_reset();
    for (int i = 0; i < 8; i++) mr[i] = 16'h0000;
    msp = 16'hFFFE;
    mip = 16'h0000;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1", "addr after reset", mem_addr, 16'h0000);
    chk("R1", "we after reset", {15'b0, mem_we}, 16'h0000);
    pend = "R1";
  endtask

  task automatic step();
    logic [15:0] iw, v, ea, imm;
    logic [7:0]  op;
    logic [3:0]  fa, fb;
    iw = mm[mip[7:0]];
    op = iw[15:8];
    fa = iw[7:4];
    fb = iw[3:0];
    chk(pend, "fetch addr", mem_addr, mip);
    chk("R2", "fetch we", {15'b0, mem_we}, 16'h0000);
    @(negedge clk);
    case (op)
      8'h01: begin
        v = rv(fb);
        mip = mip + 16'd1;
        wr(fa, v);
        pend = (fa == 4'd9) ? "R5" : ((fa > 4'd9 || fb >= 4'd9) ? "R12" : "R3");
      end
      8'h02: begin
        bus("R4", mip + 16'd1, 1'b0, 16'h0);
        imm = mm[8'(mip + 16'd1)];
        mip = mip + 16'd2;
        wr(fa, imm);
        pend = (fa == 4'd9) ? "R5" : "R4";
      end
      8'h03: begin
        mip = mip + 16'd1;
        ea = rv(fb);
        bus("R7", ea, 1'b0, 16'h0);
        wr(fa, mm[ea[7:0]]);
        pend = (fa == 4'd9) ? "R5" : "R7";
      end
      8'h04: begin
        mip = mip + 16'd1;
        ea = rv(fa);
        v = rv(fb);
        bus("R8", ea, 1'b1, v);
        mm[ea[7:0]] = v;
        pend = "R11";
      end
      8'h05: begin
        bus("R9", mip + 16'd1, 1'b0, 16'h0);
        imm = mm[8'(mip + 16'd1)];
        mip = mip + 16'd2;
        ea = rv(fa);
        bus("R9", ea, 1'b1, imm);
        mm[ea[7:0]] = imm;
        pend = "R11";
      end
      8'h06: begin
        mip = mip + 16'd1;
        v = rv(fb);
        msp = msp - 16'd1;
        bus("R10", msp, 1'b1, v);
        mm[msp[7:0]] = v;
        pend = "R11";
      end
      8'h07: begin
        mip = mip + 16'd1;
        bus("R10", msp, 1'b0, 16'h0);
        v = mm[msp[7:0]];
        msp = msp + 16'd1;
        wr(fa, v);
        pend = (fa == 4'd9) ? "R5" : "R10";
      end
      8'h10, 8'h11, 8'h12, 8'h13: begin
        mip = mip + 16'd1;
        chk("R6", "alu cycle we", {15'b0, mem_we}, 16'h0000);
        @(negedge clk);
        wr(fa, alu_ref(op[1:0], rv(fa), rv(fb)));
        pend = (fa == 4'd9) ? "R5" : "R6";
      end
      default: begin
        mip = mip + 16'd1;
        pend = "R12";
      end
    endcase
  endtask

  function automatic logic [15:0] gen_word();
    int unsigned k;
    logic [7:0]  op;
    logic [3:0]  fa, fb;
    k = $urandom_range(0, 15);
    if (k >= 14) return 16'($urandom);
    case (k)
      0, 1:    op = 8'h01;
      2, 3:    op = 8'h02;
      4:       op = 8'h03;
      5, 6:    op = 8'h04;
      7:       op = 8'h05;
      8:       op = 8'h06;
      9:       op = 8'h07;
      10:      op = 8'h10;
      11:      op = 8'h11;
      12:      op = 8'h12;
      default: op = 8'h13;
    endcase
    fa = 4'($urandom_range(0, 10));
    fb = 4'($urandom_range(0, 10));
    return {op, fa, fb};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    void'($urandom(32'd7321));
    hold_reset();
    for (int a = 0; a < 256; a++) poke(a, 16'h0000);
    // Directed program: reset values, every class, ignored codes, jump, self-modify
    poke(8'h00, 16'h0600);                       // push r0 -> R1 SP and regs
    poke(8'h01, 16'h0210); poke(8'h02, 16'h00A0); // r1 = 0x00A0
    poke(8'h03, 16'h0220); poke(8'h04, 16'h1234); // r2 = 0x1234
    poke(8'h05, 16'h0412);                       // [r1] = r2
    poke(8'h06, 16'h0331);                       // r3 = [r1]
    poke(8'h07, 16'h0603);                       // push r3
    poke(8'h08, 16'h0740);                       // pop r4
    poke(8'h09, 16'h0510); poke(8'h0A, 16'hBEEF); // [r1] = 0xBEEF
    poke(8'h0B, 16'h1042);                       // r4 &= r2
    poke(8'h0C, 16'h1342);                       // r4 = ~r2
    poke(8'h0D, 16'h1142);                       // r4 |= r2
    poke(8'h0E, 16'h1242);                       // r4 ^= r2
    poke(8'h0F, 16'h0414);                       // [r1] = r4
    poke(8'h10, 16'h01C2);                       // write to code 12: discarded
    poke(8'h11, 16'h0159);                       // r5 = IP reads zero
    poke(8'h12, 16'h0415);                       // [r1] = r5
    poke(8'h13, 16'h0EAA);                       // unknown opcode
    poke(8'h14, 16'h0290); poke(8'h15, 16'h0030); // jump to 0x30
    poke(8'h30, 16'h0260); poke(8'h31, 16'h0035); // r6 = 0x35
    poke(8'h32, 16'h0270); poke(8'h33, 16'h0174); // r7 = "mov r7,r4"
    poke(8'h34, 16'h0467);                       // [0x35] = r7, fetched next
    poke(8'h36, 16'h0417);                       // [r1] = r7
    poke(8'h37, 16'h0780);                       // pop into SP
    poke(8'h38, 16'h0608);                       // push SP
    poke(8'h39, 16'h0196);                       // jump via mov to r6
    release_reset();
    repeat (45) step();
    for (int rnd = 0; rnd < 6; rnd++) begin
      hold_reset();
      for (int a = 0; a < 256; a++) poke(a, gen_word());
      release_reset();
      repeat (300) step();
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung run expected completion");
      summary();
      $finish;
    end
  end

endmodule